// File: doc/BRIEF.md
# Programmable Bit Clock and Edge Enable Generator

This block divides a fast core clock down to a serial bit clock for an external converter. Alongside that clock it produces two internal strobes, each one core cycle wide. The launch strobe marks the rising edge of the bit clock, where transmit logic presents its next bit. The sample strobe marks the falling edge, where receive logic captures the incoming bit. Serial logic in the core clock domain can therefore use ordinary clock enables and still stay in step with both edges of the external clock.

A programmable divide value sets how many core cycles each half of the bit clock lasts, so a full bit period is twice that value. A divide value of zero behaves like one. The block captures a new divide value only when the bit clock rises, so a bit period that has already started is never cut short or stretched. When the enable input is low, the block keeps the bit clock low and sends no strobes. When the enable goes high again, a fresh period starts with a rising edge.

Top module: `bitclk_enable_gen`

## Requirements
- R1: While rst_n is low, and after reset until the first enabled cycle, bitclk_o, launch_en_o and sample_en_o are all 0.
- R2: One core cycle after en_i is sampled low, bitclk_o is 0 and neither strobe is asserted. Turning off from the high half produces no sample strobe.
- R3: On the first core clock edge at which en_i is sampled high after idle, bitclk_o goes to 1 and launch_en_o is 1 in that same output cycle.
- R4: With an effective divide value D, bitclk_o stays high for exactly D core cycles and then low for exactly D core cycles, giving a period of 2·D cycles.
- R5: launch_en_o is 1 in exactly the output cycles in which bitclk_o has just changed from 0 to 1, and it is never asserted for two cycles in a row.
- R6: sample_en_o is 1 in exactly the output cycles in which bitclk_o has just changed from 1 to 0 while enabled.
- R7: A divide value of 0 gives the same output as a divide value of 1, a period of 2 core cycles.
- R8: The block samples div_i only at the edge that raises bitclk_o. A change of div_i at any other time first affects the period that starts at the next rising edge.
- R9: launch_en_o and sample_en_o are never 1 in the same cycle, and bitclk_o changes only in a cycle with a strobe or after en_i was sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the bit clock low |
| div_i | input | DIV_W | Core cycles per half bit period (0 acts as 1) |
| bitclk_o | output | 1 | Bit clock level for the external converter |
| launch_en_o | output | 1 | One-cycle strobe in the cycle bitclk_o rises |
| sample_en_o | output | 1 | One-cycle strobe in the cycle bitclk_o falls |

## Verification
All three outputs come from registers. Their response to a stimulus shows up one core cycle after the edge that samples it. Enabling or disabling the block is visible at the next sample point, and a new divide value first changes the output in the cycle after the next rising edge of the bit clock. The bench drives inputs at falling core edges and samples at the following falling edge. It numbers the output cycles k from the first enabled cycle and compares bitclk_o and both strobes against arithmetic on k modulo 2·D. When it changes the divide value in the middle of a run, it starts a new segment of that arithmetic at the predicted rising edge.

// File: rtl/bitclk_pkg.sv
// Package: shared types for the bit clock enable generator.
// Assumes nothing beyond being compiled before the modules that import it.
package bitclk_pkg;
    // Phase of the generated bit clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;
endpackage

// File: rtl/bitclk_div_clamp.sv
// Module: bitclk_div_clamp
// Maps the programmed divide value to an effective half-period length.
// Zero is forced to one, so every half period lasts at least one core cycle.
// Purely combinational; assumes the caller registers the result.
module bitclk_div_clamp #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] raw_i,
    output logic [DIV_W-1:0] eff_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    // Replace a zero divide value by one.
    always_comb begin
        eff_o = (raw_i == '0) ? ONE : raw_i;
    end
endmodule

// File: rtl/bitclk_half_counter.sv
// Module: bitclk_half_counter
// Free-running count of core cycles spent in the current half period.
// load_i restarts the count at 1 (the first cycle of a new half).
// clear_i parks it at 0 while idle. tick_o flags the last cycle of a half.
// Assumes limit_i is at least 1 and is held stable between loads.
module bitclk_half_counter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [DIV_W-1:0] limit_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    // Advance, restart or park the half-period count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= DIV_W'(1);
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // Last cycle of the half: the count has reached the limit.
    always_comb begin
        tick_o = (cnt_q != '0) && (cnt_q == limit_i);
    end
endmodule

// File: rtl/bitclk_phase_ctrl.sv
// Module: bitclk_phase_ctrl
// Sequences idle/high/low phases and drives the registered bit clock
// and its two edge strobes. go_high_o/go_low_o are the combinational
// decisions taken at the current edge. Assumes tick_i comes from a
// counter that go_high_o/go_low_o reload.
module bitclk_phase_ctrl
    import bitclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    output logic go_high_o,
    output logic go_low_o,
    output logic bitclk_o,
    output logic launch_en_o,
    output logic sample_en_o
);
    phase_e phase_q;
    phase_e phase_d;

    // Decide the next phase and the edge events for this edge.
    always_comb begin
        phase_d   = phase_q;
        go_high_o = 1'b0;
        go_low_o  = 1'b0;
        if (!en_i) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    phase_d   = PH_HIGH;
                    go_high_o = 1'b1;
                end
                PH_HIGH: begin
                    if (tick_i) begin
                        phase_d  = PH_LOW;
                        go_low_o = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (tick_i) begin
                        phase_d   = PH_HIGH;
                        go_high_o = 1'b1;
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Register phase, bit clock level and the one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            bitclk_o    <= 1'b0;
            launch_en_o <= 1'b0;
            sample_en_o <= 1'b0;
        end else begin
            phase_q     <= phase_d;
            bitclk_o    <= (phase_d == PH_HIGH);
            launch_en_o <= go_high_o;
            sample_en_o <= go_low_o;
        end
    end
endmodule

// File: rtl/bitclk_enable_gen.sv
// Module: bitclk_enable_gen (top)
// Divides the core clock into a bit clock whose halves each last the
// effective divide value in core cycles, plus launch/sample strobes on
// its rising/falling edges. The divide value is captured only when the
// bit clock rises. Assumes div_i is synchronous to clk.
module bitclk_enable_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             bitclk_o,
    output logic             launch_en_o,
    output logic             sample_en_o
);
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] div_lat_q;
    logic             tick;
    logic             go_high;
    logic             go_low;

    bitclk_div_clamp #(.DIV_W(DIV_W)) i_clamp (
        .raw_i (div_i),
        .eff_o (div_eff)
    );

    // Capture the divide value only at the edge that raises the bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lat_q <= DIV_W'(1);
        end else if (go_high) begin
            div_lat_q <= div_eff;
        end
    end

    bitclk_half_counter #(.DIV_W(DIV_W)) i_half_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!en_i),
        .load_i  (go_high || go_low),
        .limit_i (div_lat_q),
        .tick_o  (tick)
    );

    bitclk_phase_ctrl i_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .tick_i      (tick),
        .go_high_o   (go_high),
        .go_low_o    (go_low),
        .bitclk_o    (bitclk_o),
        .launch_en_o (launch_en_o),
        .sample_en_o (sample_en_o)
    );
endmodule

// File: rtl/bitclk_enable_gen_chk.sv
// Module: bitclk_enable_gen_chk
// Port-level protocol checks for bitclk_enable_gen, attached by bind.
// Assumes synchronous active-low reset on clk.
module bitclk_enable_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic bitclk_o,
    input logic launch_en_o,
    input logic sample_en_o
);
    // R9: the two strobes are mutually exclusive.
    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch_en_o && sample_en_o));

    // R5: launch strobe coincides with a fresh high level, never twice in a row.
    assert_launch_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_en_o |-> (bitclk_o && !$past(bitclk_o) && !$past(launch_en_o)));

    // R5: every rise of the bit clock carries the launch strobe.
    assert_rise_has_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bitclk_o) |-> launch_en_o);

    // R6: sample strobe coincides with a fresh low level.
    assert_sample_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en_o |-> (!bitclk_o && $past(bitclk_o)));

    // R6: a fall while enabled carries the sample strobe.
    assert_fall_has_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bitclk_o) && $past(en_i)) |-> sample_en_o);

    // R2: after en_i is sampled low, everything is quiet.
    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (!bitclk_o && !launch_en_o && !sample_en_o));

    // R9: the clock level moves only with a strobe or a disable.
    assert_level_moves_with_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bitclk_o != $past(bitclk_o)) |-> (launch_en_o || sample_en_o || !$past(en_i)));
endmodule

bind bitclk_enable_gen bitclk_enable_gen_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .bitclk_o    (bitclk_o),
    .launch_en_o (launch_en_o),
    .sample_en_o (sample_en_o)
);

// File: tb/test_bitclk_enable_gen.sv
// Bench: sweeps divide values, checks every output cycle against
// arithmetic on the cycle index, and exercises reset, disable and
// mid-run divide changes.
module test_bitclk_enable_gen;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_i = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic             bitclk_o;
    logic             launch_en_o;
    logic             sample_en_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bitclk_enable_gen #(.DIV_W(DIV_W)) i_bitclk_enable_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .div_i       (div_i),
        .bitclk_o    (bitclk_o),
        .launch_en_o (launch_en_o),
        .sample_en_o (sample_en_o)
    );

    // Compare {bitclk, launch, sample} against an expected triple.
    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {bitclk_o, launch_en_o, sample_en_o};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t act=%b exp=%b", req, $time, act, exp);
        end
    endtask

    // Expected outputs k cycles into a run with half period d.
    function automatic logic [2:0] expect_at(input int k, input int d);
        int p;
        p = k % (2 * d);
        return {p < d, p == 0, p == d};
    endfunction

    initial begin
        // R1: reset holds outputs low even with en_i high.
        en_i  = 1'b1;
        div_i = 8'd2;
        repeat (3) begin
            @(negedge clk);
            chk("R1", 3'b000);
        end
        en_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 3'b000);

        // R4/R5/R6/R7/R9: sweep raw divide values 0..6 (0 acts as 1).
        for (int raw = 0; raw <= 6; raw++) begin
            int d;
            d = (raw == 0) ? 1 : raw;
            en_i  = 1'b0;
            div_i = DIV_W'(raw);
            repeat (2) begin
                @(negedge clk);
                chk("R2", 3'b000);
            end
            en_i = 1'b1;
            for (int k = 0; k < 8 * d; k++) begin
                @(negedge clk);
                if (k == 0)
                    chk("R3", expect_at(k, d));
                else if (raw == 0)
                    chk("R7", expect_at(k, d));
                else
                    chk("R4", expect_at(k, d));
            end
        end

        // R2: disable during the high half gives no sample strobe.
        en_i  = 1'b0;
        div_i = 8'd3;
        @(negedge clk);
        en_i = 1'b1;
        @(negedge clk);
        chk("R3", expect_at(0, 3));
        @(negedge clk);
        chk("R4", expect_at(1, 3));
        en_i = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk("R2", 3'b000);
        end
        // Re-enable: a fresh period starts with a rise.
        en_i = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk((k == 0) ? "R3" : "R4", expect_at(k, 3));
        end

        // R8: divide changes take effect only at the next rising edge.
        en_i  = 1'b0;
        div_i = 8'd3;
        @(negedge clk);
        en_i = 1'b1;
        for (int k = 0; k < 36; k++) begin
            @(negedge clk);
            if (k < 6)
                chk("R8", expect_at(k, 3));
            else if (k < 16)
                chk("R8", expect_at(k - 6, 5));
            else
                chk("R8", expect_at(k - 16, 2));
            if (k == 1) div_i = 8'd5;  // latched at the rise seen at k=6
            if (k == 8) div_i = 8'd2;  // latched at the rise seen at k=16
        end

        // R8: a change that is reverted before the rise has no effect.
        en_i  = 1'b0;
        div_i = 8'd2;
        @(negedge clk);
        en_i = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk("R8", expect_at(k, 2));
            if (k == 0) div_i = 8'd7;
            if (k == 2) div_i = 8'd2;
        end

        en_i = 1'b0;
        @(negedge clk);
        chk("R2", 3'b000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule